// File: doc/BRIEF.md
# Streaming RGB to YUV Colour-Space Converter

This block converts a stream of 8-bit unsigned red, green and blue samples into 8-bit luma (Y) and two chroma (U, V) samples. Every output channel is a weighted sum of the three inputs. The weights are signed integers in Q15 format, so 32768 stands for 1.0. The sum is then divided by 32768 with an arithmetic right shift of 15 bits. The chroma channels add a fixed bias of 128 after the shift, and every result is saturated into 0..255.

One pixel enters per cycle over a valid/ready handshake, and one Y/U/V triple leaves per cycle over a second valid/ready handshake. The pipeline has three register stages: products, sums, then shift/bias/saturate. When nothing is stalled the latency is exactly three cycles. A stalled output holds its data, and the stall reaches back through every stage. Nothing is dropped, duplicated or reordered.

Top module: `rgb_yuv_csc`

## Requirements
- R1: Y equals floor((9798*R + 19235*G + 3736*B) / 32768), with no bias added.
- R2: U equals floor((-4784*R - 9437*G + 14221*B) / 32768) + 128, saturated to 0..255.
- R3: V equals floor((20218*R - 16941*G - 3277*B) / 32768) + 128, saturated to 0..255.
- R4: The division rounds toward negative infinity, including for negative sums (for example R=255, G=B=0 gives U=90).
- R5: A result above 255 is output as 255 (for example R=255, G=B=0 gives V=255).
- R6: A result below 0 is output as 0 (for example R=0, G=B=255 gives V=0).
- R7: A pixel accepted in cycle c, with the output side ready in cycles c+1 and c+2, appears with out_valid_o high in cycle c+3.
- R8: While out_ready_i is high, in_ready_o is high, so one pixel per cycle is sustained.
- R9: While out_valid_o is high and out_ready_i is low, the next cycle keeps out_valid_o high with y_o, u_o and v_o unchanged.
- R10: Under any pattern of input gaps and output stalls, every accepted pixel leaves exactly once and in order, and at most three pixels are in flight.
- R11: During and straight after reset, out_valid_o is low and in_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Pipeline can take a pixel this cycle |
| r_i | input | 8 | Red sample, unsigned |
| g_i | input | 8 | Green sample, unsigned |
| b_i | input | 8 | Blue sample, unsigned |
| out_valid_o | output | 1 | Output triple valid |
| out_ready_i | input | 1 | Consumer takes the triple this cycle |
| y_o | output | 8 | Luma |
| u_o | output | 8 | Blue-difference chroma |
| v_o | output | 8 | Red-difference chroma |

## Verification
A corrupted product or sum register shows up as a wrong Y, U or V value exactly three cycles after the pixel is accepted. Saturated colours such as pure red and cyan expose a wrong clamp or an unsigned shift. A broken stage valid bit or stall path shows up at the ports within one cycle of a stall: the held output changes, an extra triple appears, or a triple goes missing. The stream tests catch these by counting and comparing, in order, every accepted pixel against every emitted triple.

// File: rtl/rgb_yuv_pkg.sv
package rgb_yuv_pkg;
  localparam int NCH       = 3;
  localparam int PIX_W_D   = 8;
  localparam int COEF_W_D  = 16;
  localparam int FRAC_D    = 15;

  // rows: Y, U, V ; columns: R, G, B (Q15)
  localparam int CSC_COEF [NCH][NCH] = '{
    '{  9798,  19235,  3736 },
    '{ -4784,  -9437, 14221 },
    '{ 20218, -16941, -3277 }
  };
  localparam int CSC_OFFSET [NCH] = '{0, 128, 128};
endpackage

// File: rtl/csc_pipe_ctl.sv
module csc_pipe_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic ready_o,
  output logic valid_o,
  input  logic ready_i,
  output logic load_o
);
  logic vld_q;

  assign ready_o = !vld_q || ready_i;
  assign load_o  = valid_i && ready_o;
  assign valid_o = vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q <= 1'b0;
    else if (ready_o) vld_q <= valid_i;
  end
endmodule

// File: rtl/csc_prod_stage.sv
module csc_prod_stage
  import rgb_yuv_pkg::*;
#(
  parameter int PIX_W  = PIX_W_D,
  parameter int COEF_W = COEF_W_D,
  localparam int PROD_W = PIX_W + COEF_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  output logic                     ready_o,
  input  logic [PIX_W-1:0]         pix_i  [NCH],
  output logic                     valid_o,
  input  logic                     ready_i,
  output logic signed [PROD_W-1:0] prod_o [NCH][NCH]
);
  logic load;
  logic signed [PROD_W-1:0] prod_d [NCH][NCH];
  logic signed [PROD_W-1:0] prod_q [NCH][NCH];

  csc_pipe_ctl u_ctl (
    .clk_i, .rst_ni, .valid_i, .ready_o, .valid_o, .ready_i, .load_o(load)
  );

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      for (int k = 0; k < NCH; k++) begin
        prod_d[c][k] = PROD_W'(signed'({1'b0, pix_i[k]})) *
                       PROD_W'(CSC_COEF[c][k]);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (load) prod_q <= prod_d;
  end

  assign prod_o = prod_q;
endmodule

// File: rtl/csc_acc_stage.sv
module csc_acc_stage
  import rgb_yuv_pkg::*;
#(
  parameter int PROD_W = PIX_W_D + COEF_W_D,
  localparam int ACC_W = PROD_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  output logic                     ready_o,
  input  logic signed [PROD_W-1:0] prod_i [NCH][NCH],
  output logic                     valid_o,
  input  logic                     ready_i,
  output logic signed [ACC_W-1:0]  acc_o  [NCH]
);
  logic load;
  logic signed [ACC_W-1:0] acc_d [NCH];
  logic signed [ACC_W-1:0] acc_q [NCH];

  csc_pipe_ctl u_ctl (
    .clk_i, .rst_ni, .valid_i, .ready_o, .valid_o, .ready_i, .load_o(load)
  );

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      acc_d[c] = '0;
      for (int k = 0; k < NCH; k++) acc_d[c] = acc_d[c] + ACC_W'(prod_i[c][k]);
    end
  end

  always_ff @(posedge clk_i) begin
    if (load) acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/csc_fmt_stage.sv
module csc_fmt_stage
  import rgb_yuv_pkg::*;
#(
  parameter int PIX_W = PIX_W_D,
  parameter int ACC_W = PIX_W_D + COEF_W_D + 1,
  parameter int FRAC  = FRAC_D
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  output logic                    ready_o,
  input  logic signed [ACC_W-1:0] acc_i [NCH],
  output logic                    valid_o,
  input  logic                    ready_i,
  output logic [PIX_W-1:0]        pix_o [NCH]
);
  localparam int PIX_MAX = (1 << PIX_W) - 1;

  logic load;
  logic signed [ACC_W-1:0] shifted [NCH];
  logic signed [ACC_W-1:0] biased  [NCH];
  logic [PIX_W-1:0] pix_d [NCH];
  logic [PIX_W-1:0] pix_q [NCH];

  csc_pipe_ctl u_ctl (
    .clk_i, .rst_ni, .valid_i, .ready_o, .valid_o, .ready_i, .load_o(load)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_comb begin
      shifted[c] = acc_i[c] >>> FRAC;
      biased[c]  = shifted[c] + ACC_W'(CSC_OFFSET[c]);
      if (biased[c] < 0)                        pix_d[c] = '0;
      else if (biased[c] > ACC_W'(PIX_MAX))     pix_d[c] = PIX_W'(PIX_MAX);
      else                                      pix_d[c] = biased[c][PIX_W-1:0];
    end
  end

  always_ff @(posedge clk_i) begin
    if (load) pix_q <= pix_d;
  end

  assign pix_o = pix_q;
endmodule

// File: rtl/rgb_yuv_csc.sv
module rgb_yuv_csc
  import rgb_yuv_pkg::*;
#(
  parameter int PIX_W  = PIX_W_D,
  parameter int COEF_W = COEF_W_D,
  parameter int FRAC   = FRAC_D,
  localparam int PROD_W = PIX_W + COEF_W,
  localparam int ACC_W  = PROD_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [PIX_W-1:0] r_i,
  input  logic [PIX_W-1:0] g_i,
  input  logic [PIX_W-1:0] b_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [PIX_W-1:0] y_o,
  output logic [PIX_W-1:0] u_o,
  output logic [PIX_W-1:0] v_o
);
  logic [PIX_W-1:0] pix_in  [NCH];
  logic [PIX_W-1:0] pix_out [NCH];
  logic signed [PROD_W-1:0] prod [NCH][NCH];
  logic signed [ACC_W-1:0]  acc  [NCH];
  logic vld_p, rdy_p, vld_a, rdy_a;

  assign pix_in[0] = r_i;
  assign pix_in[1] = g_i;
  assign pix_in[2] = b_i;

  csc_prod_stage #(.PIX_W(PIX_W), .COEF_W(COEF_W)) u_prod (
    .clk_i, .rst_ni,
    .valid_i(in_valid_i), .ready_o(in_ready_o), .pix_i(pix_in),
    .valid_o(vld_p), .ready_i(rdy_p), .prod_o(prod)
  );

  csc_acc_stage #(.PROD_W(PROD_W)) u_acc (
    .clk_i, .rst_ni,
    .valid_i(vld_p), .ready_o(rdy_p), .prod_i(prod),
    .valid_o(vld_a), .ready_i(rdy_a), .acc_o(acc)
  );

  csc_fmt_stage #(.PIX_W(PIX_W), .ACC_W(ACC_W), .FRAC(FRAC)) u_fmt (
    .clk_i, .rst_ni,
    .valid_i(vld_a), .ready_o(rdy_a), .acc_i(acc),
    .valid_o(out_valid_o), .ready_i(out_ready_i), .pix_o(pix_out)
  );

  assign y_o = pix_out[0];
  assign u_o = pix_out[1];
  assign v_o = pix_out[2];
endmodule

// File: rtl/rgb_yuv_csc_chk.sv
module rgb_yuv_csc_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [PIX_W-1:0] y_o,
  input logic [PIX_W-1:0] u_o,
  input logic [PIX_W-1:0] v_o
);
  logic in_fire, out_fire;
  logic [2:0] occ_q;

  assign in_fire  = in_valid_i && in_ready_o;
  assign out_fire = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else         occ_q <= occ_q + 3'(in_fire) - 3'(out_fire);
  end

  a_r7_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(in_fire, 3) && $past(out_ready_i, 2) && $past(out_ready_i, 1)) |-> out_valid_o);

  a_r8_full_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_ready_i |-> in_ready_o);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable({y_o, u_o, v_o})));

  a_r10_occupancy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q <= 3'd3) && (out_valid_o -> occ_q != 3'd0));
endmodule

bind rgb_yuv_csc rgb_yuv_csc_chk #(.PIX_W(PIX_W)) u_chk (
  .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .out_valid_o, .out_ready_i,
  .y_o, .u_o, .v_o
);

// File: tb/rgb_yuv_csc_tb.sv
module rgb_yuv_csc_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] r = '0, g = '0, b = '0;
  logic in_ready, out_valid;
  logic [7:0] y, u, v;
  int total = 0, bad = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [23:0] exp_q [$];

  always #5 clk = ~clk;

  rgb_yuv_csc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .r_i(r), .g_i(g), .b_i(b), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .y_o(y), .u_o(u), .v_o(v)
  );

  function automatic int ref_ch(int ch, int rr, int gg, int bb);
    int s;
    case (ch)
      0: s = (9798 * rr + 19235 * gg + 3736 * bb) >>> 15;
      1: s = ((-4784 * rr - 9437 * gg + 14221 * bb) >>> 15) + 128;
      default: s = ((20218 * rr - 16941 * gg - 3277 * bb) >>> 15) + 128;
    endcase
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  function automatic logic [23:0] ref_pix(logic [7:0] rr, logic [7:0] gg, logic [7:0] bb);
    return {8'(ref_ch(0, rr, gg, bb)), 8'(ref_ch(1, rr, gg, bb)), 8'(ref_ch(2, rr, gg, bb))};
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // R11: reset state
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 valid in reset", int'(out_valid), 0);
    chk("R11 ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 valid after reset", int'(out_valid), 0);
  endtask

  // one pixel, output always ready; returns latency and values
  task automatic t_one(input logic [7:0] rr, gg, bb, output int lat, output logic [7:0] yy, uu, vv);
    @(negedge clk);
    r = rr; g = gg; b = bb; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    yy = y; uu = u; vv = v;
    @(negedge clk);
  endtask

  task automatic t_colors();
    int lat;
    logic [7:0] yy, uu, vv;
    // black
    t_one(8'd0, 8'd0, 8'd0, lat, yy, uu, vv);
    chk("R7 latency", lat, 3);
    chk("R1 black Y", yy, 0);
    chk("R2 black U", uu, 128);
    chk("R3 black V", vv, 128);
    // white
    t_one(8'd255, 8'd255, 8'd255, lat, yy, uu, vv);
    chk("R1 white Y", yy, 255);
    chk("R2 white U", uu, 128);
    chk("R3 white V", vv, 128);
    // red: U floors a negative sum, V saturates high
    t_one(8'd255, 8'd0, 8'd0, lat, yy, uu, vv);
    chk("R1 red Y", yy, 76);
    chk("R4 red U floor", uu, 90);
    chk("R5 red V clamp high", vv, 255);
    // blue
    t_one(8'd0, 8'd0, 8'd255, lat, yy, uu, vv);
    chk("R1 blue Y", yy, 29);
    chk("R2 blue U", uu, 238);
    chk("R4 blue V floor", vv, 102);
    // cyan: V saturates low
    t_one(8'd0, 8'd255, 8'd255, lat, yy, uu, vv);
    chk("R6 cyan V clamp low", vv, 0);
    chk("R7 latency cyan", lat, 3);
  endtask

  // stream with optional input gaps and output stalls (R8, R9, R10, R2, R3)
  task automatic t_stream(input int n, input bit gaps);
    int sent = 0, got = 0, cyc = 0;
    bit hold = 0;
    logic [23:0] held = '0, exp;
    exp_q.delete();
    while ((sent < n || got < sent) && cyc < 5000) begin
      @(negedge clk);
      step_lfsr();
      if (hold) begin
        chk("R9 valid held", int'(out_valid), 1);
        chk("R9 data held", int'({y, u, v}), int'(held));
      end
      out_ready = gaps ? lfsr[0] | lfsr[3] : 1'b1;
      in_valid  = (sent < n) && (gaps ? lfsr[5] | lfsr[9] : 1'b1);
      r = lfsr[7:0]; g = lfsr[15:8]; b = lfsr[11:4] ^ 8'h5A;
      #1;
      if (!gaps) chk("R8 ready at full rate", int'(in_ready), 1);
      hold = out_valid && !out_ready;
      held = {y, u, v};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk("R10 spurious output", 1, 0);
        else begin
          exp = exp_q.pop_front();
          chk("R1 stream Y", int'(y), int'(exp[23:16]));
          chk("R2 stream U", int'(u), int'(exp[15:8]));
          chk("R3 stream V", int'(v), int'(exp[7:0]));
        end
        got++;
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(ref_pix(r, g, b));
        sent++;
      end
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 count out", got, n);
    if (!gaps) chk("R8 cycles", cyc, n + 3);
    repeat (4) @(negedge clk);
    chk("R10 no extra output", int'(out_valid), 0);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_colors();
    t_stream(64, 1'b0);
    t_stream(200, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule